// File: doc/BRIEF.md
# System Clock Output Pin Controller

This block drives the chip's external clock pin from the internal system clock. Three things decide what the pin does: a pin-direction bit, a clock-stop bit and the present power state. When the pin is not configured as an output, or the chip is in hardware standby, the output enable is low and the pad floats. In every other case the pin is driven. It either carries the clock or is held high.

There are two ways to hold the pin high. Software standby holds it high even when clock output is enabled. A stop request holds it high once it takes effect, and it takes effect only at a rising clock edge where the bus interface reports the end of a bus cycle. The hold is registered on the rising edge and ORed with the clock. A hold that starts or ends can therefore change the pin only while the clock is already high. Stopping never cuts a high phase short, and restarting never produces a pulse shorter than half a period.

Top module: `ckout_pin_ctrl`

## Requirements
- R1: With `dir_out` = 0, `pin_oe` is 0 in every power state.
- R2: With power state code 3 (hardware standby), `pin_oe` is 0 whatever the register bits. Codes 5 to 7 are handled the same way.
- R3: With `dir_out` = 1 and power state code 0 (run), 1 (sleep) or 4 (all module clocks stopped), `pin_oe` is 1. When no stop is in effect, `pin_out` is high in each high phase and low in each low phase of `clk`.
- R4: With power state code 2 (software standby) and `dir_out` = 1, `pin_oe` is 1. `pin_out` stays high in both clock phases from the first rising edge that samples the code.
- R5: While `stop_req` is 1 and `bus_end` has not been 1 at a rising edge, the clock keeps appearing on `pin_out`.
- R6: A rising edge that samples `stop_req` = 1 together with `bus_end` = 1 holds `pin_out` high from that edge onward. The hold lasts as long as `stop_req` stays 1, with no further `bus_end` needed.
- R7: After a rising edge that samples `stop_req` = 0, `pin_out` first goes low at the next falling edge. No high phase on the pin is shorter than half a clock period.
- R8: While `rst` is sampled high, `pin_out` is held high in both phases. `pin_oe` still follows R1 and R2.
- R9: A `bus_end` strobe seen while `stop_req` is 0 is not remembered. A later `stop_req` = 1 waits for a fresh `bus_end`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal system clock; source of the pin clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_out | input | 1 | Pin direction bit, 1 = output |
| stop_req | input | 1 | Clock-stop control bit |
| bus_end | input | 1 | Strobe, high in the last cycle of a bus access |
| pwr_state | input | 3 | Power state code (0 run, 1 sleep, 2 software standby, 3 hardware standby, 4 all module clocks stopped) |
| pin_out | output | 1 | Level for the clock pad |
| pin_oe | output | 1 | Output enable for the clock pad |

## Verification
The bench builds the block with the package's three-bit power-state encoding, so all eight codes can be swept, the unused ones included. It steps through every combination of direction, stop bit, state code and bus-end strobe, starting each one from a running clock. Both the high and the low phase of every cycle are compared against a small stop-flag model kept in the bench. Directed sequences then cover a delayed stop, a stop that lasts after the strobe, a release, and a stray strobe before a stop request.

// File: rtl/ckout_pkg.sv
package ckout_pkg;

    localparam int PS_W = 3;

    typedef enum logic [PS_W-1:0] {
        PS_RUN     = 3'd0,
        PS_SLEEP   = 3'd1,
        PS_SWSTBY  = 3'd2,
        PS_HWSTBY  = 3'd3,
        PS_ALLSTOP = 3'd4
    } pwr_state_e;

    typedef struct packed {
        logic drive;
        logic force_high;
    } pin_mode_t;

    // Pad may be driven in every state except hardware standby and unused codes
    function automatic logic state_drives(input logic [PS_W-1:0] code);
        case (code)
            PS_RUN, PS_SLEEP, PS_SWSTBY, PS_ALLSTOP: return 1'b1;
            default:                                 return 1'b0;
        endcase
    endfunction

    // States in which the pin level is forced high even with clock output enabled
    function automatic logic state_forces_high(input logic [PS_W-1:0] code);
        return (code == PS_SWSTBY) || !state_drives(code);
    endfunction

endpackage

// File: rtl/ckout_stop_track.sv
module ckout_stop_track (
    input  logic clk,
    input  logic rst,
    input  logic stop_req,
    input  logic bus_end,
    output logic stop_next,
    output logic stop_q
);
    // A stop arms only on a bus-cycle boundary; clearing the bit disarms at once
    always_comb begin
        if (!stop_req) stop_next = 1'b0;
        else           stop_next = stop_q | bus_end;
    end

    always_ff @(posedge clk) begin
        if (rst) stop_q <= 1'b0;
        else     stop_q <= stop_next;
    end

    a_r5_no_early_stop: assert property (@(posedge clk) disable iff (rst)
        (stop_req && !bus_end && !stop_q) |=> !stop_q);

    a_r9_no_memory: assert property (@(posedge clk) disable iff (rst)
        !stop_req |=> !stop_q);

endmodule

// File: rtl/ckout_mode_dec.sv
module ckout_mode_dec
    import ckout_pkg::*;
(
    input  logic            dir_out,
    input  logic [PS_W-1:0] pwr_state,
    output pin_mode_t       mode
);
    always_comb begin
        mode.drive      = dir_out && state_drives(pwr_state);
        mode.force_high = state_forces_high(pwr_state);
    end
endmodule

// File: rtl/ckout_gate.sv
module ckout_gate (
    input  logic clk,
    input  logic rst,
    input  logic hold_req,
    output logic hold_q,
    output logic pin
);
    // Hold changes only at a rising edge, while clk is high, so OR gating is glitch-free
    always_ff @(posedge clk) begin
        if (rst) hold_q <= 1'b1;
        else     hold_q <= hold_req;
    end

    assign pin = clk | hold_q;

endmodule

// File: rtl/ckout_pin_ctrl.sv
module ckout_pin_ctrl
    import ckout_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            dir_out,
    input  logic            stop_req,
    input  logic            bus_end,
    input  logic [PS_W-1:0] pwr_state,
    output logic            pin_out,
    output logic            pin_oe
);
    logic      stop_next;
    logic      stop_q;
    logic      hold_q;
    pin_mode_t mode;

    ckout_stop_track u_stop (
        .clk      (clk),
        .rst      (rst),
        .stop_req (stop_req),
        .bus_end  (bus_end),
        .stop_next(stop_next),
        .stop_q   (stop_q)
    );

    ckout_mode_dec u_dec (
        .dir_out  (dir_out),
        .pwr_state(pwr_state),
        .mode     (mode)
    );

    ckout_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .hold_req(stop_next | mode.force_high),
        .hold_q  (hold_q),
        .pin     (pin_out)
    );

    assign pin_oe = mode.drive;

    a_r2_hw_float: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == PS_HWSTBY) |-> !pin_oe);

    a_r4_sw_high: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == PS_SWSTBY) |=> hold_q);

    a_r6_stop_holds: assert property (@(posedge clk) disable iff (rst)
        (stop_req && bus_end) |=> hold_q);

    a_r7_release: assert property (@(posedge clk) disable iff (rst)
        (!stop_req && dir_out && state_drives(pwr_state) && pwr_state != PS_SWSTBY)
        |=> !hold_q);

    a_r1_float: assert property (@(posedge clk) disable iff (rst)
        !dir_out |-> !pin_oe);

endmodule

// File: tb/ckout_pin_ctrl_bench.sv
module ckout_pin_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dir_out = 1'b0;
    logic       stop_req = 1'b0;
    logic       bus_end = 1'b0;
    logic [2:0] pwr_state = 3'd0;
    logic       pin_out;
    logic       pin_oe;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;
    bit    m_stop = 0;
    bit    m_hold = 1;
    string ctx = "R3";

    always #5 clk = ~clk;

    ckout_pin_ctrl u_ckout_pin_ctrl (
        .clk(clk), .rst(rst), .dir_out(dir_out), .stop_req(stop_req),
        .bus_end(bus_end), .pwr_state(pwr_state), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit drives(input logic [2:0] p);
        return (p == 0) || (p == 1) || (p == 2) || (p == 4);
    endfunction

    // One clock cycle: check previous low phase, drive, then check high phase
    task automatic cyc(input bit r, input bit d, input bit s, input logic [2:0] p, input bit b);
        string oe_tag;
        string lo_tag;
        @(negedge clk);
        #1;
        lo_tag = rst ? "R8" : (pwr_state == 2 ? "R4" : ctx);
        check(lo_tag, pin_out, m_hold);
        rst = r; dir_out = d; stop_req = s; pwr_state = p; bus_end = b;
        @(posedge clk);
        if (r)          m_stop = 0;
        else if (!s)    m_stop = 0;
        else if (b)     m_stop = 1;
        m_hold = r | m_stop | (p == 2) | !drives(p);
        #2;
        oe_tag = !d ? "R1" : (!drives(p) ? "R2" : (p == 2 ? "R4" : "R3"));
        check(oe_tag, pin_oe, d && drives(p));
        check("R7", pin_out, 1'b1);
    endtask

    initial begin
        repeat (3) cyc(1, 1, 0, 0, 0);
        ctx = "R8";
        cyc(1, 0, 1, 3, 1);
        ctx = "R3";
        repeat (2) cyc(0, 1, 0, 0, 0);

        // Near-exhaustive sweep over direction, stop bit, state code and strobe
        for (int d = 0; d < 2; d++)
            for (int s = 0; s < 2; s++)
                for (int p = 0; p < 8; p++)
                    for (int b = 0; b < 2; b++) begin
                        ctx = "R3";
                        repeat (2) cyc(0, 1, 0, 0, 0);
                        ctx = (s != 0) ? ((b != 0) ? "R6" : "R5") : "R3";
                        repeat (3) cyc(0, d[0], s[0], p[2:0], b[0]);
                    end

        // R5: stop requested, no bus-cycle end yet -> clock keeps running
        ctx = "R3"; repeat (2) cyc(0, 1, 0, 0, 0);
        ctx = "R5"; repeat (5) cyc(0, 1, 1, 1, 0);
        // R6: strobe arrives, pin stays high afterwards without strobe
        ctx = "R6"; cyc(0, 1, 1, 1, 1);
        repeat (5) cyc(0, 1, 1, 4, 0);
        // R7: release, clock resumes at next falling edge
        ctx = "R7"; repeat (4) cyc(0, 1, 0, 0, 0);
        // R9: stray strobe while stop clear is forgotten
        ctx = "R9"; cyc(0, 1, 0, 0, 1);
        repeat (4) cyc(0, 1, 1, 0, 0);
        cyc(0, 1, 1, 0, 1);
        repeat (2) cyc(0, 1, 1, 0, 0);
        // R4 exit back to run with clock enabled
        ctx = "R4"; repeat (2) cyc(0, 1, 0, 2, 0);
        ctx = "R3"; repeat (3) cyc(0, 1, 0, 0, 0);
        @(negedge clk); #1;
        check("R3", pin_out, m_hold);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule